// File: doc/BRIEF.md
# PLL Recalibration Sequencer

This block is a small master on the memory-mapped reconfiguration port of an on-chip fractional PLL. On a start pulse it first asks for user access to the PLL's internal configuration bus. It then polls a status register until that access is granted and sets the calibration-request bit with a read-modify-write. Last, it releases the bus so that the PLL's own calibration engine can run. It then follows the PLL's calibration-busy and lock inputs. The sequence is judged good only if busy rises, busy falls again and lock then rises.

Each of the four waits (grant, busy rising, busy falling, lock) has its own programmable timeout. An expired wait ends the run with an error code that names the step that failed. A second command applies a PLL reset through the reset register: it writes 1 and then 0 to that bit. A parameter can make the block start one run by itself after reset, once a programmable settle delay has passed. While a run is in progress, `busy_o` is high and new commands are ignored. The final `done_o` or `err_o` stays set until the next command is accepted.

Top module: `pllcal_seq`

## Requirements
- R1: The first bus access of a calibration run is a write of data 0x2 to address 0x000 (access request).
- R2: After the request, the block reads address 0x280 repeatedly and moves on only once bit 2 of the read value is 0. If the grant limit expires first, the run ends with `err_o`=1 and `err_code_o`=1.
- R3: Once the grant is seen, the block reads address 0x100 and writes back to 0x100 the value read with bit 1 set and all other bits unchanged.
- R4: After that write, the block writes data 0x1 to address 0x000 (bus release). It is the last bus access of a run.
- R5: After the release, cal_busy must go high within the rise limit, or the run ends with code 2. It must then go low within the fall limit, or the run ends with code 3.
- R6: After cal_busy falls, lock must go high within the lock limit. If it does, the run ends with `done_o`=1. If it does not, the run ends with code 4.
- R7: A reset command writes 0x1 and then 0x0 to address 0x2E0, makes no other bus access, and ends with `done_o`=1.
- R8: Address, read, write and write data stay stable while waitrequest is high. Read and write are never high together. Read data is taken only in the cycle the read completes.
- R9: While `busy_o` is high, start and reset commands are ignored. `done_o` and `err_o` are never high together, both clear when a command is accepted, and both then hold until the next accepted command.
- R10: With AUTO_START=1, the block is busy straight out of reset. It issues its first access request only after the settle limit has counted down.
- R11: After reset (AUTO_START=0), busy, done and error are low, the error code is 0, and no bus access is made while the block is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a recalibration run (pulse) |
| prst_i | input | 1 | Start a PLL reset command (pulse) |
| settle_lim_i | input | TW | Settle delay before the automatic start |
| grant_lim_i | input | TW | Timeout for the bus grant poll |
| rise_lim_i | input | TW | Timeout for cal_busy to rise |
| fall_lim_i | input | TW | Timeout for cal_busy to fall |
| lock_lim_i | input | TW | Timeout for lock |
| av_addr_o | output | AW | Bus address |
| av_read_o | output | 1 | Bus read command |
| av_write_o | output | 1 | Bus write command |
| av_wdata_o | output | DW | Bus write data |
| av_rdata_i | input | DW | Bus read data |
| av_waitreq_i | input | 1 | Bus wait request |
| cal_busy_i | input | 1 | PLL calibration busy |
| lock_i | input | 1 | PLL lock |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last command finished without error |
| err_o | output | 1 | Last command ended in error |
| err_code_o | output | 3 | Failing step: 1 grant, 2 no busy rise, 3 busy stuck, 4 no lock |

## Verification
The hardest case to reach is the read-modify-write seen under wait states. In that case the read data is valid only in the cycle the read completes, and a wrong sample would corrupt the write-back value. The bus model in the bench holds waitrequest high for a set number of cycles per access and returns a poison value while it is high. Vectors with several wait states therefore expose a capture taken too early. The timeout branches are reached by giving the PLL model delays longer than the matching limit: a busy pulse that comes too late, a busy that never falls, a late lock, and a grant bit that never clears.

// File: rtl/pllcal_pkg.sv
package pllcal_pkg;

    localparam int unsigned OFS_ARB  = 'h000;
    localparam int unsigned OFS_STAT = 'h280;
    localparam int unsigned OFS_CAL  = 'h100;
    localparam int unsigned OFS_PRST = 'h2E0;

    localparam int unsigned GNT_BIT  = 2;
    localparam int unsigned CAL_BIT  = 1;
    localparam int unsigned PRST_BIT = 0;

    localparam int unsigned ARB_TAKE = 'h2;
    localparam int unsigned ARB_GIVE = 'h1;

    localparam int unsigned NTMR   = 5;
    localparam int unsigned T_SET  = 0;
    localparam int unsigned T_GNT  = 1;
    localparam int unsigned T_RISE = 2;
    localparam int unsigned T_FALL = 3;
    localparam int unsigned T_LOCK = 4;

    typedef enum logic [3:0] {
        ST_IDLE, ST_SETTLE, ST_REQ, ST_POLL, ST_RMW_RD, ST_RMW_WR,
        ST_REL, ST_WRISE, ST_WFALL, ST_WLOCK, ST_PR_SET, ST_PR_CLR
    } st_e;

    typedef enum logic [2:0] {
        EC_NONE  = 3'd0,
        EC_GRANT = 3'd1,
        EC_RISE  = 3'd2,
        EC_FALL  = 3'd3,
        EC_LOCK  = 3'd4
    } ec_e;

endpackage

// File: rtl/pllcal_tmr.sv
module pllcal_tmr #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] lim_i,
    input  logic          en_i,
    output logic          exp_o
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = lim_i;
        else if (en_i && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign exp_o = (cnt_q == '0);
endmodule

// File: rtl/pllcal_bus.sv
module pllcal_bus #(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_vld_i,
    input  logic          cmd_wr_i,
    input  logic [AW-1:0] cmd_addr_i,
    input  logic [DW-1:0] cmd_wdata_i,
    input  logic          abort_i,
    output logic          rsp_vld_o,
    output logic [DW-1:0] rsp_data_o,
    output logic [AW-1:0] av_addr_o,
    output logic          av_read_o,
    output logic          av_write_o,
    output logic [DW-1:0] av_wdata_o,
    input  logic [DW-1:0] av_rdata_i,
    input  logic          av_waitreq_i
);
    typedef struct packed {
        logic          act;
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          rsp;
        logic [DW-1:0] rdata;
    } bus_s;

    bus_s q, d;

    always_comb begin
        d     = q;
        d.rsp = 1'b0;
        if (abort_i) begin
            d.act = 1'b0;
        end else if (q.act) begin
            if (!av_waitreq_i) begin
                d.act = 1'b0;
                d.rsp = 1'b1;
                if (!q.wr) d.rdata = av_rdata_i;
            end
        end else if (cmd_vld_i) begin
            d.act   = 1'b1;
            d.wr    = cmd_wr_i;
            d.addr  = cmd_addr_i;
            d.wdata = cmd_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign av_addr_o  = q.addr;
    assign av_wdata_o = q.wdata;
    assign av_read_o  = q.act && !q.wr;
    assign av_write_o = q.act && q.wr;
    assign rsp_vld_o  = q.rsp;
    assign rsp_data_o = q.rdata;
endmodule

// File: rtl/pllcal_seq.sv
module pllcal_seq
    import pllcal_pkg::*;
#(
    parameter int AW         = 10,
    parameter int DW         = 32,
    parameter int TW         = 16,
    parameter bit AUTO_START = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          prst_i,
    input  logic [TW-1:0] settle_lim_i,
    input  logic [TW-1:0] grant_lim_i,
    input  logic [TW-1:0] rise_lim_i,
    input  logic [TW-1:0] fall_lim_i,
    input  logic [TW-1:0] lock_lim_i,
    output logic [AW-1:0] av_addr_o,
    output logic          av_read_o,
    output logic          av_write_o,
    output logic [DW-1:0] av_wdata_o,
    input  logic [DW-1:0] av_rdata_i,
    input  logic          av_waitreq_i,
    input  logic          cal_busy_i,
    input  logic          lock_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o,
    output logic [2:0]    err_code_o
);
    localparam st_e ST_RST = AUTO_START ? ST_SETTLE : ST_IDLE;

    typedef struct packed {
        st_e           st;
        logic          fresh;
        logic          done;
        logic          err;
        ec_e           code;
        logic [DW-1:0] data;
    } seq_s;

    seq_s q, d;

    logic            cmd_vld, cmd_wr, bus_abort, bus_rsp;
    logic [AW-1:0]   cmd_addr;
    logic [DW-1:0]   cmd_wdata, bus_rdata;
    logic [NTMR-1:0] tld, ten, texp;
    logic [TW-1:0]   tlim [NTMR];

    assign tlim[T_SET]  = settle_lim_i;
    assign tlim[T_GNT]  = grant_lim_i;
    assign tlim[T_RISE] = rise_lim_i;
    assign tlim[T_FALL] = fall_lim_i;
    assign tlim[T_LOCK] = lock_lim_i;

    for (genvar gi = 0; gi < NTMR; gi++) begin : g_tmr
        pllcal_tmr #(.TW(TW)) u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (tld[gi]),
            .lim_i  (tlim[gi]),
            .en_i   (ten[gi]),
            .exp_o  (texp[gi])
        );
    end

    pllcal_bus #(.AW(AW), .DW(DW)) u_bus (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_vld_i    (cmd_vld),
        .cmd_wr_i     (cmd_wr),
        .cmd_addr_i   (cmd_addr),
        .cmd_wdata_i  (cmd_wdata),
        .abort_i      (bus_abort),
        .rsp_vld_o    (bus_rsp),
        .rsp_data_o   (bus_rdata),
        .av_addr_o    (av_addr_o),
        .av_read_o    (av_read_o),
        .av_write_o   (av_write_o),
        .av_wdata_o   (av_wdata_o),
        .av_rdata_i   (av_rdata_i),
        .av_waitreq_i (av_waitreq_i)
    );

    always_comb begin
        d         = q;
        cmd_vld   = 1'b0;
        cmd_wr    = 1'b1;
        cmd_addr  = '0;
        cmd_wdata = '0;
        bus_abort = 1'b0;
        tld       = '0;
        ten       = '0;
        case (q.st)
            ST_IDLE: begin
                if (start_i || prst_i) begin
                    d.st    = start_i ? ST_REQ : ST_PR_SET;
                    d.fresh = 1'b1;
                    d.done  = 1'b0;
                    d.err   = 1'b0;
                    d.code  = EC_NONE;
                end
            end
            ST_SETTLE: begin
                if (q.fresh) begin
                    tld[T_SET] = 1'b1;
                    d.fresh    = 1'b0;
                end else if (texp[T_SET]) begin
                    d.st    = ST_REQ;
                    d.fresh = 1'b1;
                end else begin
                    ten[T_SET] = 1'b1;
                end
            end
            ST_REQ: begin
                cmd_addr  = AW'(OFS_ARB);
                cmd_wdata = DW'(ARB_TAKE);
                if (bus_rsp) begin
                    d.st       = ST_POLL;
                    d.fresh    = 1'b1;
                    tld[T_GNT] = 1'b1;
                end
            end
            ST_POLL: begin
                cmd_wr   = 1'b0;
                cmd_addr = AW'(OFS_STAT);
                if (bus_rsp) begin
                    d.fresh = 1'b1;
                    if (!bus_rdata[GNT_BIT]) d.st = ST_RMW_RD;
                end else if (texp[T_GNT]) begin
                    bus_abort = 1'b1;
                    d.st      = ST_IDLE;
                    d.err     = 1'b1;
                    d.code    = EC_GRANT;
                end else begin
                    ten[T_GNT] = 1'b1;
                end
            end
            ST_RMW_RD: begin
                cmd_wr   = 1'b0;
                cmd_addr = AW'(OFS_CAL);
                if (bus_rsp) begin
                    d.data  = bus_rdata;
                    d.st    = ST_RMW_WR;
                    d.fresh = 1'b1;
                end
            end
            ST_RMW_WR: begin
                cmd_addr  = AW'(OFS_CAL);
                cmd_wdata = q.data | (DW'(1) << CAL_BIT);
                if (bus_rsp) begin
                    d.st    = ST_REL;
                    d.fresh = 1'b1;
                end
            end
            ST_REL: begin
                cmd_addr  = AW'(OFS_ARB);
                cmd_wdata = DW'(ARB_GIVE);
                if (bus_rsp) begin
                    d.st        = ST_WRISE;
                    tld[T_RISE] = 1'b1;
                end
            end
            ST_WRISE: begin
                if (cal_busy_i) begin
                    d.st        = ST_WFALL;
                    tld[T_FALL] = 1'b1;
                end else if (texp[T_RISE]) begin
                    d.st   = ST_IDLE;
                    d.err  = 1'b1;
                    d.code = EC_RISE;
                end else begin
                    ten[T_RISE] = 1'b1;
                end
            end
            ST_WFALL: begin
                if (!cal_busy_i) begin
                    d.st        = ST_WLOCK;
                    tld[T_LOCK] = 1'b1;
                end else if (texp[T_FALL]) begin
                    d.st   = ST_IDLE;
                    d.err  = 1'b1;
                    d.code = EC_FALL;
                end else begin
                    ten[T_FALL] = 1'b1;
                end
            end
            ST_WLOCK: begin
                if (lock_i) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end else if (texp[T_LOCK]) begin
                    d.st   = ST_IDLE;
                    d.err  = 1'b1;
                    d.code = EC_LOCK;
                end else begin
                    ten[T_LOCK] = 1'b1;
                end
            end
            ST_PR_SET: begin
                cmd_addr  = AW'(OFS_PRST);
                cmd_wdata = DW'(1) << PRST_BIT;
                if (bus_rsp) begin
                    d.st    = ST_PR_CLR;
                    d.fresh = 1'b1;
                end
            end
            ST_PR_CLR: begin
                cmd_addr  = AW'(OFS_PRST);
                cmd_wdata = '0;
                if (bus_rsp) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (q.fresh && q.st != ST_IDLE && q.st != ST_SETTLE && !bus_abort) begin
            cmd_vld = 1'b1;
            d.fresh = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_RST;
            q.fresh <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy_o     = (q.st != ST_IDLE);
    assign done_o     = q.done;
    assign err_o      = q.err;
    assign err_code_o = q.code;
endmodule

// File: rtl/pllcal_seq_chk.sv
module pllcal_seq_chk #(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          prst_i,
    input logic [AW-1:0] av_addr_o,
    input logic          av_read_o,
    input logic          av_write_o,
    input logic [DW-1:0] av_wdata_o,
    input logic          av_waitreq_i,
    input logic          bus_abort,
    input logic          busy_o,
    input logic          done_o,
    input logic          err_o,
    input logic [2:0]    err_code_o
);
    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (av_read_o || av_write_o) && av_waitreq_i && !bus_abort |=>
        av_read_o == $past(av_read_o) && av_write_o == $past(av_write_o) &&
        $stable(av_addr_o) && $stable(av_wdata_o)); // R8

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(av_read_o && av_write_o)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !av_read_o && !av_write_o); // R11

    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o)); // R9

    AST_BUSY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !done_o && !err_o); // R9

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && !start_i && !prst_i |=>
        $stable(done_o) && $stable(err_o) && $stable(err_code_o)); // R9

    AST_CODE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        err_o == (err_code_o != 3'd0)); // R6

    AST_ARB_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        av_write_o && av_addr_o == '0 |-> av_wdata_o == DW'(1) || av_wdata_o == DW'(2)); // R4
endmodule

bind pllcal_seq pllcal_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .prst_i       (prst_i),
    .av_addr_o    (av_addr_o),
    .av_read_o    (av_read_o),
    .av_write_o   (av_write_o),
    .av_wdata_o   (av_wdata_o),
    .av_waitreq_i (av_waitreq_i),
    .bus_abort    (bus_abort),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_o        (err_o),
    .err_code_o   (err_code_o)
);

// File: tb/pllcal_seq_tb.sv
`timescale 1ns/1ps
module pllcal_seq_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;

    logic        start, prst;
    logic [9:0]  addr;
    logic        rd, wr, waitreq, cal_busy, lock;
    logic [31:0] wdata, rdata;
    logic        busy, done, err;
    logic [2:0]  code;

    pllcal_seq #(.AW(10), .DW(32), .TW(16), .AUTO_START(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .prst_i(prst),
        .settle_lim_i(16'd10), .grant_lim_i(16'd40), .rise_lim_i(16'd20),
        .fall_lim_i(16'd50), .lock_lim_i(16'd30),
        .av_addr_o(addr), .av_read_o(rd), .av_write_o(wr), .av_wdata_o(wdata),
        .av_rdata_i(rdata), .av_waitreq_i(waitreq),
        .cal_busy_i(cal_busy), .lock_i(lock),
        .busy_o(busy), .done_o(done), .err_o(err), .err_code_o(code)
    );

    logic [9:0]  a_addr;
    logic        a_rd, a_wr, a_busy, a_done, a_err;
    logic [31:0] a_wdata;
    logic [2:0]  a_code;

    pllcal_seq #(.AW(10), .DW(32), .TW(16), .AUTO_START(1'b1)) u_auto (
        .clk(clk), .rst_n(rst_n), .start_i(1'b0), .prst_i(1'b0),
        .settle_lim_i(16'd50), .grant_lim_i(16'd40), .rise_lim_i(16'd20),
        .fall_lim_i(16'd50), .lock_lim_i(16'd30),
        .av_addr_o(a_addr), .av_read_o(a_rd), .av_write_o(a_wr), .av_wdata_o(a_wdata),
        .av_rdata_i(32'd0), .av_waitreq_i(1'b0),
        .cal_busy_i(1'b0), .lock_i(1'b0),
        .busy_o(a_busy), .done_o(a_done), .err_o(a_err), .err_code_o(a_code)
    );

    // PLL and bus model
    logic        mdl_clr;
    int          cfg_ws, cfg_polls, cfg_bdly, cfg_blen, cfg_ldly;
    logic [31:0] cfg_seed;
    int          ws_cnt, polls_left, cal_t, wcnt, rd280, hold_err;
    logic        cal_on, h_pend, h_rd, h_wr;
    logic [9:0]  h_addr;
    logic [31:0] h_data, reg100;
    logic [9:0]  wlog_a [16];
    logic [31:0] wlog_d [16];

    assign waitreq  = (rd || wr) && (ws_cnt < cfg_ws);
    assign rdata    = waitreq ? 32'hDEAD_BEEF :
                      (addr == 10'h280) ? {29'd0, polls_left != 0, 2'b00} :
                      (addr == 10'h100) ? reg100 : 32'd0;
    assign cal_busy = cal_on && cal_t >= cfg_bdly && cal_t < cfg_bdly + cfg_blen;
    assign lock     = cal_on && cal_t >= cfg_bdly + cfg_blen + cfg_ldly;

    always @(posedge clk) begin
        if (mdl_clr) begin
            ws_cnt <= 0; polls_left <= cfg_polls; cal_t <= 0; cal_on <= 1'b0;
            wcnt <= 0; rd280 <= 0; hold_err <= 0; h_pend <= 1'b0; reg100 <= cfg_seed;
        end else begin
            if (cal_on) cal_t <= cal_t + 1;
            if (h_pend && !(rd == h_rd && wr == h_wr && addr == h_addr && wdata == h_data))
                hold_err <= hold_err + 1;
            h_pend <= (rd || wr) && waitreq;
            h_rd <= rd; h_wr <= wr; h_addr <= addr; h_data <= wdata;
            if (rd || wr) begin
                if (waitreq) ws_cnt <= ws_cnt + 1;
                else begin
                    ws_cnt <= 0;
                    if (wr) begin
                        if (wcnt < 16) begin
                            wlog_a[wcnt[3:0]] <= addr;
                            wlog_d[wcnt[3:0]] <= wdata;
                        end
                        wcnt <= wcnt + 1;
                        if (addr == 10'h100) reg100 <= wdata;
                        if (addr == 10'h000 && wdata == 32'd1) begin
                            cal_on <= 1'b1; cal_t <= 0;
                        end
                    end else if (addr == 10'h280) begin
                        rd280 <= rd280 + 1;
                        if (polls_left != 0) polls_left <= polls_left - 1;
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    task automatic model_reset(input int ws, input int polls, input int bdly,
                               input int blen, input int ldly, input logic [31:0] seed);
        cfg_ws = ws; cfg_polls = polls; cfg_bdly = bdly; cfg_blen = blen;
        cfg_ldly = ldly; cfg_seed = seed;
        mdl_clr = 1'b1;
        @(negedge clk);
        mdl_clr = 1'b0;
    endtask

    task automatic pulse(input bit is_start);
        if (is_start) start = 1'b1; else prst = 1'b1;
        @(negedge clk);
        start = 1'b0; prst = 1'b0;
    endtask

    typedef struct packed {
        logic [3:0]  ws;
        logic [7:0]  polls;
        logic [7:0]  bdly;
        logic [11:0] blen;
        logic [7:0]  ldly;
        logic [31:0] seed;
        logic [2:0]  code;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{4'd0, 8'd0,   8'd2,   12'd5,    8'd3,   32'hA5A5_0040, 3'd0},
        '{4'd2, 8'd3,   8'd5,   12'd10,   8'd0,   32'h1234_5679, 3'd0},
        '{4'd3, 8'd5,   8'd1,   12'd4,    8'd2,   32'hFFFF_FFFD, 3'd0},
        '{4'd1, 8'd200, 8'd2,   12'd5,    8'd3,   32'h0000_0000, 3'd1},
        '{4'd0, 8'd1,   8'd100, 12'd5,    8'd3,   32'h0F0F_0F0F, 3'd2},
        '{4'd1, 8'd0,   8'd1,   12'd1000, 8'd3,   32'h8000_0001, 3'd3},
        '{4'd0, 8'd2,   8'd3,   12'd4,    8'd100, 32'h0000_0002, 3'd4}
    };

    initial begin
        int  t;
        bit  seen;
        start = 1'b0; prst = 1'b0; mdl_clr = 1'b1;
        cfg_ws = 0; cfg_polls = 0; cfg_bdly = 0; cfg_blen = 0; cfg_ldly = 0; cfg_seed = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(!busy && !done && !err, "R11", "flags after reset", {busy, done, err}, 0);
        chk(code == 3'd0, "R11", "error code after reset", code, 0);
        chk(!rd && !wr, "R11", "bus idle after reset", {rd, wr}, 0);
        // R10 automatic start
        chk(a_busy, "R10", "auto instance busy after reset", a_busy, 1);
        t = 1; seen = 1'b0;
        while (t < 80 && !seen) begin
            if (a_wr) seen = 1'b1; else begin @(negedge clk); t++; end
        end
        chk(seen && t >= 50 && t <= 58, "R10", "first request cycle after settle", t, 53);
        chk(a_addr == 10'h000 && a_wdata == 32'd2, "R10", "auto request write", a_wdata, 2);
        mdl_clr = 1'b0;

        // table of vectors
        for (int v = 0; v < NVEC; v++) begin
            vec_t  cv;
            string tag;
            cv = VECS[v];
            model_reset(int'(cv.ws), int'(cv.polls), int'(cv.bdly), int'(cv.blen),
                        int'(cv.ldly), cv.seed);
            pulse(1'b1);
            chk(busy && !done && !err, "R9", "flags cleared at start", {busy, done, err}, 4);
            wait_idle();
            tag = (cv.code == 3'd0) ? "R6" : (cv.code == 3'd1) ? "R2" :
                  (cv.code == 3'd4) ? "R6" : "R5";
            chk(!busy && done == (cv.code == 3'd0) && err == (cv.code != 3'd0),
                tag, "end flags", {busy, done, err}, (cv.code == 3'd0) ? 2 : 1);
            chk(code == cv.code, tag, "error code", code, cv.code);
            chk(wcnt >= 1 && wlog_a[0] == 10'h000 && wlog_d[0] == 32'd2, "R1",
                "access request write", wlog_d[0], 2);
            if (cv.code == 3'd1) begin
                chk(wcnt == 1, "R2", "no write after grant timeout", wcnt, 1);
            end else begin
                chk(wcnt == 3, "R4", "write count", wcnt, 3);
                chk(rd280 == int'(cv.polls) + 1, "R2", "status polls", rd280, cv.polls + 1);
                chk(wlog_a[1] == 10'h100 && wlog_d[1] == (cv.seed | 32'h2), "R3",
                    "read-modify-write value", wlog_d[1], cv.seed | 32'h2);
                chk(wlog_a[2] == 10'h000 && wlog_d[2] == 32'd1, "R4", "release write",
                    wlog_d[2], 1);
                chk(hold_err == 0, "R8", "command stable under waitrequest", hold_err, 0);
            end
        end

        // R9 commands ignored while busy, flags sticky
        model_reset(1, 2, 4, 6, 2, 32'h0000_1000);
        pulse(1'b1);
        repeat (6) @(negedge clk);
        start = 1'b1; prst = 1'b1;
        @(negedge clk);
        start = 1'b0; prst = 1'b0;
        wait_idle();
        chk(done && !err, "R9", "run completes despite extra commands", {done, err}, 2);
        chk(wcnt == 3 && wlog_d[0] == 32'd2, "R9", "extra commands issued no access", wcnt, 3);
        repeat (30) @(negedge clk);
        chk(done && !busy && wcnt == 3, "R9", "done held while idle", {busy, done}, 1);

        // R7 PLL reset command
        model_reset(1, 0, 2, 5, 3, 32'h0);
        pulse(1'b0);
        wait_idle();
        chk(done && !err, "R7", "reset command done", {done, err}, 2);
        chk(wcnt == 2, "R7", "reset command write count", wcnt, 2);
        chk(wlog_a[0] == 10'h2E0 && wlog_d[0] == 32'd1, "R7", "reset set write", wlog_d[0], 1);
        chk(wlog_a[1] == 10'h2E0 && wlog_d[1] == 32'd0, "R7", "reset clear write", wlog_d[1], 0);
        chk(rd280 == 0, "R7", "no poll during reset command", rd280, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule